// File: doc/BRIEF.md
# Shared Mailbox Array with Interrupt Aggregation

This block holds a small array of 32-bit mailbox slots that processors use to pass single-word messages. A sender writes a slot with bit 31 set; that bit marks the slot as holding a message, and the other 31 bits carry the payload. The receiver reads the word and then writes zero to free the slot.

Every slot presents two level conditions: it holds a message (FULL) or it holds none (EMPTY). The block gathers these conditions into one live status word. A set of interrupt outputs, each with its own enable mask, turns the status word into a few shared interrupt lines.

A read-only sizing word reports how many slots and interrupt lines are built. When a build parameter selects it, each slot also has two local enable bits that decide whether its FULL and EMPTY conditions reach the status word. Software reaches all of this over a plain single-cycle register bus. Reads are combinational on the address.

Top module: `shmbox_array`

## Requirements
- R1: After reset every slot word reads 0, every interrupt enable word and every per-slot enable reads 0, the status word reads 0 and every `irq` bit is low.
- R2: A write to slot i (byte address 0x10000 + i*0x8000) stores the full 32-bit word, and a read returns it. While bit 31 of the stored word is 1 and FULL is enabled for the slot, status bit 8+i is 1.
- R3: Writing zero to a slot clears the whole word, including bit 31. While the slot's bit 31 is 0 and EMPTY is enabled for the slot, status bit i is 1.
- R4: A write with bit 31 set to a slot that is already full replaces the payload, and bit 31 stays 1.
- R5: The status word at address 0x304 is read-only. A write to that address changes no slot, no enable and no status bit.
- R6: Interrupt enable word x sits at address 0x100 + 4*x. It stores bits 15:0 of a write, and bits 31:16 read as 0.
- R7: `irq[x]` is 1 exactly while some status bit is 1 whose enable bit in word x is also 1. It is a level: it stays 1 for as long as that condition holds.
- R8: The sizing word at address 0x380 reads the slot count in bits 3:0 and the interrupt-line count in bits 19:16. Bits 15:4 and 31:20 read 0. Writes to it have no effect.
- R9: With PER_SLOT_IE=1, slot i has a FULL enable at slot address + 0x4 and an EMPTY enable at slot address + 0x8. Each stores bit 0 of a write, and its other bits read 0. A 0 in that bit blocks the matching condition from the status word.
- R10: A read of any address not listed above returns 0, and a write to such an address changes nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one transfer per cycle |
| addr | input | ADDR_W (20) | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | NUM_IRQ (2) | Shared level interrupt lines |

## Verification
The assertions assume that `addr`, `wdata` and `wr_en` are stable and known at each rising edge, and that a write counts once per cycle in which `wr_en` is high. They also assume NUM_SLOTS is at most 8 and NUM_IRQ at most 15, so that each count fits its 4-bit field in the sizing word. The bench changes inputs only at falling edges and holds `wr_en` for exactly one cycle per write. It reads `rdata` and `irq` a short time after a falling edge, when the preceding rising edge has already taken effect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] SLOT_BASE    = 32'h0001_0000;
  localparam logic [31:0] SLOT_STRIDE  = 32'h0000_8000;
  localparam logic [31:0] IE_BASE      = 32'h0000_0100;
  localparam logic [31:0] STAT_ADDR    = 32'h0000_0304;
  localparam logic [31:0] DIM_ADDR     = 32'h0000_0380;
  localparam logic [31:0] FULL_IE_OFS  = 32'h4;
  localparam logic [31:0] EMPTY_IE_OFS = 32'h8;
  localparam int          MAX_SLOTS    = 8;
  localparam int          FULL_FLAG    = 31;

  // byte address of a slot register
  function automatic logic [31:0] slot_addr(input int idx, input logic [31:0] ofs);
    return SLOT_BASE + SLOT_STRIDE * 32'(idx) + ofs;
  endfunction

  // byte address of an interrupt enable word
  function automatic logic [31:0] ie_addr(input int idx);
    return IE_BASE + 32'(4 * idx);
  endfunction

  // sizing word: slot count low nibble, interrupt lines at bits 19:16
  function automatic logic [31:0] dim_word(input int nslot, input int nirq);
    logic [3:0] s, q;
    s = 4'(nslot);
    q = 4'(nirq);
    return {12'h000, q, 12'h000, s};
  endfunction

  // status word: EMPTY conditions low byte, FULL conditions next byte
  function automatic logic [15:0] status_word(input logic [7:0] empty_v,
                                              input logic [7:0] full_v);
    return {full_v, empty_v};
  endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int IDX         = 0,
  parameter bit PER_SLOT_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       data_q,
  output logic              full_ie,
  output logic              empty_ie,
  output logic              stat_full,
  output logic              stat_empty
);
  localparam logic [31:0] A_DATA = slot_addr(IDX, 32'h0);
  localparam logic [31:0] A_FIE  = slot_addr(IDX, FULL_IE_OFS);
  localparam logic [31:0] A_EIE  = slot_addr(IDX, EMPTY_IE_OFS);

  logic [31:0] addr32;
  logic        wr_data, wr_fie, wr_eie;

  assign addr32  = 32'(addr);
  assign wr_data = wr_en && (addr32 == A_DATA);
  assign wr_fie  = wr_en && (addr32 == A_FIE);
  assign wr_eie  = wr_en && (addr32 == A_EIE);

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= wdata;
  end

  generate
    if (PER_SLOT_IE) begin : g_local_ie
      logic fie_q, eie_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          fie_q <= 1'b0;
          eie_q <= 1'b0;
        end else begin
          if (wr_fie) fie_q <= wdata[0];
          if (wr_eie) eie_q <= wdata[0];
        end
      end
      assign full_ie  = fie_q;
      assign empty_ie = eie_q;

      // R9: clearing the local FULL enable removes the slot's FULL bit
      assert_fie_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fie && !wdata[0]) |=> !stat_full);
    end else begin : g_fixed_ie
      assign full_ie  = 1'b1;
      assign empty_ie = 1'b1;
    end
  endgenerate

  assign stat_full  = data_q[FULL_FLAG] && full_ie;
  assign stat_empty = !data_q[FULL_FLAG] && empty_ie;

  // R4: a flagged write leaves the slot full with the new word
  assert_overwrite_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && wdata[FULL_FLAG]) |=> (data_q[FULL_FLAG] && data_q == $past(wdata)));

  // R3: a zero write empties the whole word
  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && wdata == 32'h0) |=> (data_q == 32'h0 && !stat_full));
endmodule

// File: rtl/mbx_irq_gate.sv
module mbx_irq_gate
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata_lo,
  input  logic [15:0]       status,
  output logic [15:0]       en_q,
  output logic              irq
);
  localparam logic [31:0] A_EN = ie_addr(IDX);

  logic wr_hit;
  assign wr_hit = wr_en && (32'(addr) == A_EN);

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wdata_lo;
  end

  assign irq = |(status & en_q);

  // R6: the enable word takes the low half of a write
  assert_en_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(wdata_lo)));

  // R7: with nothing enabled the line stays low
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 16'h0) |-> !irq);
endmodule

// File: rtl/shmbox_array.sv
module shmbox_array
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int NUM_SLOTS   = 8,
  parameter int NUM_IRQ     = 2,
  parameter bit PER_SLOT_IE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_IRQ-1:0] irq
);
  localparam logic [31:0] DIM_VALUE = dim_word(NUM_SLOTS, NUM_IRQ);

  logic [31:0] slot_data [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_fie, slot_eie;
  logic [MAX_SLOTS-1:0] empty_v, full_v;
  logic [15:0] status_w;
  logic [15:0] en_w [NUM_IRQ];
  logic [31:0] addr32;

  assign addr32 = 32'(addr);

  generate
    for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
      if (i < NUM_SLOTS) begin : g_live
        mbx_slot #(.ADDR_W(ADDR_W), .IDX(i), .PER_SLOT_IE(PER_SLOT_IE)) u_slot (
          .clk       (clk),
          .rst_n     (rst_n),
          .wr_en     (wr_en),
          .addr      (addr),
          .wdata     (wdata),
          .data_q    (slot_data[i]),
          .full_ie   (slot_fie[i]),
          .empty_ie  (slot_eie[i]),
          .stat_full (full_v[i]),
          .stat_empty(empty_v[i])
        );
      end else begin : g_absent
        assign full_v[i]  = 1'b0;
        assign empty_v[i] = 1'b0;
      end
    end

    for (genvar x = 0; x < NUM_IRQ; x++) begin : g_irq
      mbx_irq_gate #(.ADDR_W(ADDR_W), .IDX(x)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata_lo(wdata[15:0]),
        .status  (status_w),
        .en_q    (en_w[x]),
        .irq     (irq[x])
      );
    end
  endgenerate

  assign status_w = status_word(empty_v, full_v);

  always_comb begin
    rdata = 32'h0;
    if (addr32 == STAT_ADDR) rdata = {16'h0, status_w};
    if (addr32 == DIM_ADDR)  rdata = DIM_VALUE;
    for (int x = 0; x < NUM_IRQ; x++) begin
      if (addr32 == ie_addr(x)) rdata = {16'h0, en_w[x]};
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr32 == slot_addr(i, 32'h0)) rdata = slot_data[i];
      if (PER_SLOT_IE && addr32 == slot_addr(i, FULL_IE_OFS))  rdata = {31'h0, slot_fie[i]};
      if (PER_SLOT_IE && addr32 == slot_addr(i, EMPTY_IE_OFS)) rdata = {31'h0, slot_eie[i]};
    end
  end

  // R5: a write aimed at the status word leaves it unchanged
  assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr32 == STAT_ADDR) |=> $stable(status_w));

  // R8: a write aimed at the sizing word leaves all status intact
  assert_dim_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr32 == DIM_ADDR) |=> $stable(status_w));
endmodule

// File: tb/tb_shmbox_array.sv
`timescale 1ns/1ps
module tb_shmbox_array;
  localparam int ADDR_W = 20;
  localparam int NIRQ   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NIRQ-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shmbox_array #(.ADDR_W(ADDR_W), .NUM_SLOTS(8), .NUM_IRQ(NIRQ), .PER_SLOT_IE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [19:0] a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1,  20'h00304, 32'h0000_0000}, // R1 status idle
    '{1'b0, 4'd1,  20'h10000, 32'h0000_0000}, // R1 slot0 empty
    '{1'b0, 4'd8,  20'h00380, 32'h0002_0008}, // R8 sizing word
    '{1'b1, 4'd9,  20'h10004, 32'h0000_0001}, // R9 slot0 FULL enable
    '{1'b1, 4'd9,  20'h10008, 32'h0000_0003}, // R9 slot0 EMPTY enable
    '{1'b0, 4'd9,  20'h10008, 32'h0000_0001}, // R9 only bit0 kept
    '{1'b0, 4'd3,  20'h00304, 32'h0000_0001}, // R3 EMPTY bit0
    '{1'b1, 4'd2,  20'h10000, 32'h8000_1234},
    '{1'b0, 4'd2,  20'h10000, 32'h8000_1234}, // R2 word stored
    '{1'b0, 4'd2,  20'h00304, 32'h0000_0100}, // R2 FULL bit8
    '{1'b1, 4'd4,  20'h10000, 32'h8000_5678},
    '{1'b0, 4'd4,  20'h10000, 32'h8000_5678}, // R4 overwrite
    '{1'b0, 4'd4,  20'h00304, 32'h0000_0100}, // R4 still full
    '{1'b1, 4'd5,  20'h00304, 32'hFFFF_FFFF},
    '{1'b0, 4'd5,  20'h00304, 32'h0000_0100}, // R5 read-only
    '{1'b0, 4'd5,  20'h10000, 32'h8000_5678}, // R5 slot untouched
    '{1'b1, 4'd3,  20'h10000, 32'h0000_0000},
    '{1'b0, 4'd3,  20'h10000, 32'h0000_0000}, // R3 cleared
    '{1'b0, 4'd3,  20'h00304, 32'h0000_0001}, // R3 EMPTY back
    '{1'b1, 4'd9,  20'h48000, 32'hCAFE_BABE},
    '{1'b0, 4'd2,  20'h48000, 32'hCAFE_BABE}, // R2 slot7 stored
    '{1'b0, 4'd9,  20'h00304, 32'h0000_0001}, // R9 slot7 gated off
    '{1'b1, 4'd9,  20'h48004, 32'h0000_0001},
    '{1'b0, 4'd9,  20'h00304, 32'h0000_8001}, // R9 slot7 FULL bit15
    '{1'b1, 4'd9,  20'h48004, 32'hFFFF_FFFE},
    '{1'b0, 4'd9,  20'h48004, 32'h0000_0000}, // R9 bit0 low
    '{1'b0, 4'd9,  20'h00304, 32'h0000_0001}, // R9 gated again
    '{1'b1, 4'd6,  20'h00100, 32'hFFFF_FFFF},
    '{1'b0, 4'd6,  20'h00100, 32'h0000_FFFF}, // R6 upper bits zero
    '{1'b1, 4'd6,  20'h00104, 32'h0000_0100},
    '{1'b0, 4'd6,  20'h00104, 32'h0000_0100}, // R6 line1 enable
    '{1'b1, 4'd8,  20'h00380, 32'h0000_0000},
    '{1'b0, 4'd8,  20'h00380, 32'h0002_0008}, // R8 write ignored
    '{1'b1, 4'd10, 20'h02000, 32'h1234_5678},
    '{1'b0, 4'd10, 20'h02000, 32'h0000_0000}  // R10 unmapped
  };

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [19:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic [NIRQ-1:0] exp);
    @(negedge clk);
    #1;
    chk(tag, 32'(irq), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_chk("R1 irq after reset", 2'b00);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].a, VEC[k].d);
      else rd($sformatf("R%0d vector %0d", VEC[k].req, k), VEC[k].a, VEC[k].d);
    end

    // state: slot0 empty (both enables on), slot7 full but gated, en0=FFFF, en1=0100
    irq_chk("R7 empty drives line0 only", 2'b01);
    wr(20'h10000, 32'h8000_0001);
    irq_chk("R7 full drives both lines", 2'b11);
    wr(20'h00104, 32'h0000_0001);
    irq_chk("R7 line1 on EMPTY mask, slot full", 2'b01);
    wr(20'h10000, 32'h0000_0000);
    for (int c = 0; c < 4; c++) irq_chk("R7 EMPTY level holds", 2'b11);
    wr(20'h00100, 32'h0000_0000);
    irq_chk("R7 line0 disabled", 2'b10);
    wr(20'h10008, 32'h0000_0000);
    irq_chk("R9 EMPTY gated removes line1", 2'b00);

    // reset in the middle of activity
    wr(20'h00100, 32'h0000_FFFF);
    wr(20'h10008, 32'h0000_0001);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 slot7 cleared", 20'h48000, 32'h0);
    rd("R1 enable0 cleared", 20'h00100, 32'h0);
    rd("R1 local EMPTY enable cleared", 20'h10008, 32'h0);
    rd("R1 status cleared", 20'h00304, 32'h0);
    irq_chk("R1 irq low after reset", 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule